// File: doc/BRIEF.md
# Memory PHY Latency Alignment Unit

This block sits between a memory controller and a DRAM physical-layer model. It turns command-side events into data-side qualifiers. A read-issue pulse from the controller comes back as a read-data-valid indication a programmed number of controller clock cycles later. A write command comes back as a DQS-burst enable a separately programmed number of cycles later. Both latencies are run-time inputs, and the block honours them only after calibration has reported success.

The block latches the two latency inputs on the rising edge of the calibration-success input. From then until the next reset, the latched values stay fixed, whatever the latency inputs or the calibration input do. Before the latch is taken, every read-issue and write event is dropped. In half-rate operation the read-issue input and the read-valid output are 2-bit vectors, one bit per half-word phase. The phase pattern is kept across the delay, so read data that does not start on a full-word boundary can be flagged. A write burst opens on a cycle where a write command and write-data issue are both high. The burst stays open while write-data issue is held, and the DQS enable copies that length.

Top module: `phy_lat_align`

## Requirements
- R1: On the first rising edge of `cal_ok` after reset, the block captures `rd_lat_in` and `wr_lat_in`. Read-issue and write events count from the next cycle onward.
- R2: Until that capture, `rd_valid` and `dqs_burst_en` stay 0, and read-issue or write events presented in that time never produce output later.
- R3: Once captured, the latencies stay fixed until reset. Later changes on `rd_lat_in` or `wr_lat_in`, and later falls and rises of `cal_ok`, have no effect on output timing.
- R4: A read-issue vector presented in cycle c appears unchanged on `rd_valid` in cycle c+RL, where RL is the captured read latency (0 to 63). With RL = 0 it appears in the same cycle.
- R5: With RL = 9, `rd_valid` first goes non-zero exactly 9 cycles after a single read-issue cycle.
- R6: Back-to-back read-issue cycles give back-to-back valid cycles, with no bubble and the same count.
- R7: In half-rate mode, bit 0 of `rd_issue`/`rd_valid` is the first half-word phase and bit 1 the second. Patterns such as 2'b10 followed by 2'b01 come out in the same order and shape.
- R8: A burst stream is high in cycle c when `wr_data_issue` is high and either `wr_cmd` is high in c or the stream was high in c-1. `dqs_burst_en` in cycle c+WL equals the stream in cycle c, where WL is the captured write latency.
- R9: `wr_data_issue` with no write command opening the burst is ignored: `dqs_burst_en` stays low for it.
- R10: A synchronous active-low `rst_n` clears all in-flight read and write events and the calibration latch. No event issued before reset appears after it.
- R11: Read and write paths are independent: a read-valid cycle and a DQS-enable cycle that fall in the same cycle are both produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_ok | input | 1 | Calibration success; its rising edge captures the latencies |
| rd_lat_in | input | LAT_W | Advertised read latency in cycles |
| wr_lat_in | input | LAT_W | Advertised write latency in cycles |
| rd_issue | input | PH | Read-issue vector, one bit per phase (PH = 2 in half-rate, else 1) |
| wr_cmd | input | 1 | Write command issued (chip select asserted) |
| wr_data_issue | input | 1 | Write-data issue, held for the burst length |
| rd_valid | output | PH | Read-data-valid per phase |
| dqs_burst_en | output | 1 | DQS-burst enable |

## Verification
The read-valid output and the DQS-burst enable can fall in the same cycle. This happens when a read issued in cycle c and a write command issued in cycle c+RL-WL land together. The bench provokes this with read latency 9 and write latency 4, issuing the write five cycles after a read. It then runs long stretches of mixed traffic at several latency pairs, including 0 and 63. A behavioural model schedules both kinds of event in a future-cycle table and compares both outputs every cycle. A collision that drops or delays either output is therefore reported.

// File: rtl/phy_lat_pkg.sv
package phy_lat_pkg;

  typedef enum logic {
    LK_WAIT = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;

  // number of phase bits on the read qualifiers
  function automatic int phase_count(bit half_rate);
    return half_rate ? 2 : 1;
  endfunction

  // stage that holds an event issued 'lat' cycles ago (lat >= 1)
  function automatic int unsigned tap_index(int unsigned lat);
    return (lat == 0) ? 0 : lat - 1;
  endfunction

endpackage

// File: rtl/lat_lock.sv
module lat_lock
  import phy_lat_pkg::*;
#(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_ok,
  input  logic [LAT_W-1:0] rd_lat_in,
  input  logic [LAT_W-1:0] wr_lat_in,
  output logic             locked,
  output logic             cal_rise,
  output logic [LAT_W-1:0] rd_lat_q,
  output logic [LAT_W-1:0] wr_lat_q
);

  lock_state_e st;
  logic        cal_q;

  assign cal_rise = cal_ok & ~cal_q;
  assign locked   = (st == LK_HELD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LK_WAIT;
      cal_q    <= 1'b0;
      rd_lat_q <= '0;
      wr_lat_q <= '0;
    end else begin
      cal_q <= cal_ok;
      if (st == LK_WAIT && cal_rise) begin
        st       <= LK_HELD;
        rd_lat_q <= rd_lat_in;
        wr_lat_q <= wr_lat_in;
      end
    end
  end

endmodule

// File: rtl/tap_delay.sv
module tap_delay
  import phy_lat_pkg::*;
#(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [LAT_W-1:0] lat,
  output logic             dout
);

  localparam int DEPTH = 1 << LAT_W;

  logic             stage [DEPTH];
  logic [LAT_W-1:0] tap;

  assign tap = LAT_W'(tap_index(32'(lat)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= 1'b0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = (lat == '0) ? din : stage[tap];

endmodule

// File: rtl/wr_burst_gen.sv
module wr_burst_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wr_cmd,
  input  logic wr_data_issue,
  output logic burst_now
);

  logic burst_prev;

  assign burst_now = enable & wr_data_issue & (wr_cmd | burst_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) burst_prev <= 1'b0;
    else        burst_prev <= burst_now;
  end

endmodule

// File: rtl/phy_lat_align.sv
module phy_lat_align
  import phy_lat_pkg::*;
#(
  parameter int LAT_W     = 6,
  parameter bit HALF_RATE = 1'b1,
  localparam int PH       = phase_count(HALF_RATE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_ok,
  input  logic [LAT_W-1:0] rd_lat_in,
  input  logic [LAT_W-1:0] wr_lat_in,
  input  logic [PH-1:0]    rd_issue,
  input  logic             wr_cmd,
  input  logic             wr_data_issue,
  output logic [PH-1:0]    rd_valid,
  output logic             dqs_burst_en
);

  // named internal events, observed by the bound checker
  logic             locked;
  logic             cal_rise;
  logic [LAT_W-1:0] rd_lat_q;
  logic [LAT_W-1:0] wr_lat_q;
  logic [PH-1:0]    rd_fire;
  logic             wr_stream;

  lat_lock #(.LAT_W(LAT_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_ok   (cal_ok),
    .rd_lat_in(rd_lat_in),
    .wr_lat_in(wr_lat_in),
    .locked   (locked),
    .cal_rise (cal_rise),
    .rd_lat_q (rd_lat_q),
    .wr_lat_q (wr_lat_q)
  );

  assign rd_fire = rd_issue & {PH{locked}};

  for (genvar p = 0; p < PH; p++) begin : g_phase
    tap_delay #(.LAT_W(LAT_W)) u_rd_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rd_fire[p]),
      .lat  (rd_lat_q),
      .dout (rd_valid[p])
    );
  end

  wr_burst_gen u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (locked),
    .wr_cmd       (wr_cmd),
    .wr_data_issue(wr_data_issue),
    .burst_now    (wr_stream)
  );

  tap_delay #(.LAT_W(LAT_W)) u_wr_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wr_stream),
    .lat  (wr_lat_q),
    .dout (dqs_burst_en)
  );

endmodule

// File: rtl/phy_lat_align_chk.sv
module phy_lat_align_chk #(
  parameter int LAT_W = 6,
  parameter int PH    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic             cal_rise,
  input logic [LAT_W-1:0] rd_lat_q,
  input logic [LAT_W-1:0] wr_lat_q,
  input logic [PH-1:0]    rd_fire,
  input logic             wr_stream,
  input logic             wr_cmd,
  input logic [PH-1:0]    rd_valid,
  input logic             dqs_burst_en
);

  // R1: the latch is only taken on a calibration rising edge
  p_lock_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cal_rise));

  // R2: nothing comes out before the latch is taken
  p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (rd_valid == '0 && !dqs_burst_en));

  // R3: latched latencies never move while held
  p_lat_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(rd_lat_q) && $stable(wr_lat_q)));

  // R4: zero read latency passes through in the same cycle
  p_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rd_lat_q == '0) |-> (rd_valid == rd_fire));

  // R4: unit read latency is one cycle behind the issue
  p_rd_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && rd_lat_q == LAT_W'(1)) |-> (rd_valid == $past(rd_fire)));

  // R8: unit write latency is one cycle behind the burst stream
  p_wr_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && wr_lat_q == LAT_W'(1)) |-> (dqs_burst_en == $past(wr_stream)));

  // R9: a burst cycle without a command must continue an open burst
  p_burst_opened_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stream && !wr_cmd) |-> $past(wr_stream));

endmodule

bind phy_lat_align phy_lat_align_chk #(.LAT_W(LAT_W), .PH(PH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .locked      (locked),
  .cal_rise    (cal_rise),
  .rd_lat_q    (rd_lat_q),
  .wr_lat_q    (wr_lat_q),
  .rd_fire     (rd_fire),
  .wr_stream   (wr_stream),
  .wr_cmd      (wr_cmd),
  .rd_valid    (rd_valid),
  .dqs_burst_en(dqs_burst_en)
);

// File: tb/phy_lat_align_tb.sv
module phy_lat_align_tb;

  localparam int LW = 6;
  localparam int PH = 2;
  localparam int RING = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_ok = 1'b0;
  logic [LW-1:0] rd_lat_in = '0;
  logic [LW-1:0] wr_lat_in = '0;
  logic [PH-1:0] rd_issue = '0;
  logic          wr_cmd = 1'b0;
  logic          wr_data_issue = 1'b0;
  logic [PH-1:0] rd_valid;
  logic          dqs_burst_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  phy_lat_align #(.LAT_W(LW), .HALF_RATE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_ok(cal_ok),
    .rd_lat_in(rd_lat_in), .wr_lat_in(wr_lat_in),
    .rd_issue(rd_issue), .wr_cmd(wr_cmd), .wr_data_issue(wr_data_issue),
    .rd_valid(rd_valid), .dqs_burst_en(dqs_burst_en)
  );

  // behavioural model: future-cycle tables
  bit [PH-1:0] ring_rd [RING];
  bit          ring_wr [RING];
  bit          m_locked = 0, m_calq = 0, m_bprev = 0;
  int          m_rl = 0, m_wl = 0;

  always @(negedge clk) begin
    bit [PH-1:0] e_rd;
    bit          e_wr, b;
    b    = m_locked && wr_data_issue && (wr_cmd || m_bprev);
    e_rd = ring_rd[cyc % RING];
    e_wr = ring_wr[cyc % RING];
    if (m_locked && m_rl == 0) e_rd = e_rd | rd_issue;
    if (m_wl == 0 && b) e_wr = 1'b1;
    total++;
    if (rd_valid !== e_rd || dqs_burst_en !== e_wr) begin
      bad++;
      $display("FAIL %s cycle %0d rd_valid=%b exp=%b dqs_burst_en=%b exp=%b",
               tag, cyc, rd_valid, e_rd, dqs_burst_en, e_wr);
    end
    ring_rd[cyc % RING] = '0;
    ring_wr[cyc % RING] = 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < RING; i++) begin ring_rd[i] = '0; ring_wr[i] = 1'b0; end
      m_locked = 0; m_calq = 0; m_bprev = 0; m_rl = 0; m_wl = 0;
    end else begin
      if (m_locked && m_rl > 0)
        ring_rd[(cyc + m_rl) % RING] = ring_rd[(cyc + m_rl) % RING] | rd_issue;
      if (b && m_wl > 0) ring_wr[(cyc + m_wl) % RING] = 1'b1;
      m_bprev = b;
      if (!m_locked && cal_ok && !m_calq) begin
        m_locked = 1; m_rl = int'(rd_lat_in); m_wl = int'(wr_lat_in);
      end
      m_calq = cal_ok;
    end
    cyc++;
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    rd_issue = '0; wr_cmd = 1'b0; wr_data_issue = 1'b0;
  endtask

  task automatic relock(int rl, int wl);
    rst_n = 1'b0; cal_ok = 1'b0; idle();
    step(2);
    rst_n = 1'b1; rd_lat_in = LW'(rl); wr_lat_in = LW'(wl);
    step(1);
    cal_ok = 1'b1;
    step(1);
  endtask

  task automatic traffic(int n);
    for (int i = 0; i < n; i++) begin
      rd_issue      = PH'($urandom % 4);
      wr_cmd        = ($urandom % 5) == 0;
      wr_data_issue = ($urandom % 3) != 0;
      step(1);
    end
    idle();
  endtask

  task automatic direct_check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int n;
    int hits;
    step(3);
    @(negedge clk);
    direct_check(rd_valid == '0 && !dqs_burst_en, "R10 reset state", int'(rd_valid), 0);
    @(posedge clk); #1;

    // R2: events before calibration are dropped
    rst_n = 1'b1; tag = "R2";
    rd_lat_in = 6'd9; wr_lat_in = 6'd4;
    rd_issue = 2'b11; wr_cmd = 1'b1; wr_data_issue = 1'b1;
    step(3); idle(); step(15);

    // R1: capture on cal_ok rise
    tag = "R1";
    cal_ok = 1'b1; step(1);
    rd_lat_in = 6'd2; wr_lat_in = 6'd1;  // ignored from here (R3)
    step(2);

    // R5: single read, count cycles to valid
    tag = "R5";
    rd_issue = 2'b11; step(1); idle();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rd_valid != '0) break;
      n++;
    end
    direct_check(n == 8, "R5 cycles after issue cycle to valid", n + 1, 9);
    step(12);

    // R6: back-to-back reads, count valid cycles
    tag = "R6";
    rd_issue = 2'b11; step(5); idle();
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rd_valid == 2'b11) hits++;
    end
    direct_check(hits == 5, "R6 valid cycle count", hits, 5);
    step(2);

    // R7: unaligned half-rate pattern
    tag = "R7";
    rd_issue = 2'b10; step(1);
    rd_issue = 2'b11; step(2);
    rd_issue = 2'b01; step(1); idle(); step(12);

    // R3: latency inputs and cal_ok toggles ignored
    tag = "R3";
    cal_ok = 1'b0; rd_lat_in = 6'd3; step(2);
    cal_ok = 1'b1; step(1);
    rd_issue = 2'b01; step(1); idle(); step(12);

    // R8: burst of three after a command
    tag = "R8";
    wr_cmd = 1'b1; wr_data_issue = 1'b1; step(1);
    wr_cmd = 1'b0; step(2); idle(); step(8);

    // R9: data issue alone is ignored
    tag = "R9";
    wr_data_issue = 1'b1; step(4); idle(); step(8);

    // R11: read valid and DQS enable in the same cycle
    tag = "R11";
    rd_issue = 2'b11; step(1); idle(); step(4);
    wr_cmd = 1'b1; wr_data_issue = 1'b1; step(1); idle(); step(12);
    tag = "R11 mixed";
    traffic(300); step(12);

    // R10: reset wipes in-flight reads
    tag = "R10";
    rd_issue = 2'b11; step(3); idle();
    rst_n = 1'b0; step(1); rst_n = 1'b1; step(15);

    // R4: other latency pairs, including the extremes
    tag = "R4 rl0 wl1";  relock(0, 1);   traffic(400); step(70);
    tag = "R4 rl1 wl0";  relock(1, 0);   traffic(400); step(70);
    tag = "R4 rl63 wl63"; relock(63, 63); traffic(400); step(70);
    tag = "R4 rl17 wl2"; relock(17, 2);  traffic(400); step(70);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule